// File: doc/BRIEF.md
# Sparse-Tap Reloadable FIR Channel Filter

This block models one transmit-to-receive path of a radio channel emulator in the time domain. A long history of input samples is kept, but only a small, fixed number of taps multiply it. Each tap has its own programmable delay, which picks one position in the history, and its own signed coefficient. Each output sample is the full-precision sum of these few products, so a sparse multipath profile costs one multiplier per path rather than one per delay position.

Channel profiles change slowly compared with the sample rate. A host loads the next profile, one tap at a time, into a shadow bank while the active bank keeps filtering. A single-cycle swap strobe then copies the whole shadow bank into the active bank, so the profile changes cleanly between two samples. The shadow bank keeps its contents after a swap. The next profile can therefore be written as a set of edits to the previous one.

Top module: `sparse_tap_fir`

## Requirements
- R1: After reset, out_valid is 0 and out_acc is 0. Every active and shadow tap has coefficient 0 and delay 0, and the sample history holds zeros, so outputs stay 0 until a profile is swapped in.
- R2: out_valid is in_valid delayed by exactly two clock cycles: a sample accepted at clock edge t gives out_valid high in the cycle after edge t+1.
- R3: Each output equals the sum over all taps k of coef_k × x(n − d_k). x(n) is the sample accepted with this output (delay 0 is the newest sample), d_k is the 0-based delay of tap k, and the sum is taken as signed full precision. Positions never written since reset read as 0.
- R4: The sample history advances only on cycles with in_valid high. Idle cycles neither shift it nor insert samples.
- R5: A shadow write (cfg_we high, with cfg_tap, cfg_delay and cfg_coef) changes no output until a later swap.
- R6: cfg_swap high for one cycle copies every shadow tap into the active bank. A sample accepted in the same cycle as the swap, or later, uses the new profile. Samples accepted before it still complete with the old profile.
- R7: A shadow write in the same cycle as a swap is not part of that swap. It takes effect at the next swap.
- R8: The shadow bank keeps its contents across a swap. A swap with no writes since the last swap leaves the profile unchanged, and rewriting one tap changes only that tap.
- R9: Several taps may point at the same delay, and their products add.
- R10: The output does not overflow. With every tap at coefficient −32768 (0x8000) and every sample at −8192 (0x2000), the output equals 2147483648.
- R11: While out_valid is low, out_acc holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_sample | input | 14 | Signed input sample |
| cfg_we | input | 1 | Write one shadow tap |
| cfg_tap | input | 3 | Tap slot to write |
| cfg_delay | input | 5 | Delay of the tap, 0 = newest sample |
| cfg_coef | input | 16 | Signed coefficient of the tap |
| cfg_swap | input | 1 | Copy shadow bank into active bank |
| out_valid | output | 1 | Output sample present |
| out_acc | output | 36 | Signed full-precision filter output |

## Verification
The embedded properties assume that every control input is a known 0 or 1 on each rising edge and that reset is applied synchronously for at least one edge. Unless the history depth is a power of two, they also assume that the host never writes a delay beyond the history depth. The bench changes all inputs only on falling edges and returns every control line to 0 between operations. It uses only delays inside the default depth of 32 and tap indices inside the default count of 8. Swaps and colliding writes are placed deliberately in the middle of sample streams so that the profile boundary is tested while samples are still in flight.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

   // Smallest accumulator width that cannot overflow for a given shape
   function automatic int sfir_acc_need(input int data_w, input int coef_w, input int ntaps);
      return data_w + coef_w + $clog2(ntaps);
   endfunction

   localparam int SFIR_DATA_W = 14;
   localparam int SFIR_COEF_W = 16;
   localparam int SFIR_ACC_W  = 36;
   localparam int SFIR_NTAPS  = 8;
   localparam int SFIR_DEPTH  = 32;

endpackage

// File: rtl/sfir_history.sv
module sfir_history #(
   parameter int DATA_W = 14,
   parameter int DEPTH  = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           shift_en,
   input  logic [DATA_W-1:0]              din,
   output logic [DEPTH-1:0][DATA_W-1:0]   hist_o
);

   logic [DEPTH-1:0][DATA_W-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (shift_en) begin
         hist_q[0] <= din;
         for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
      end
   end

   assign hist_o = hist_q;

   // R4
   history_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/sfir_bank.sv
module sfir_bank #(
   parameter int NTAPS  = 8,
   parameter int DLY_W  = 5,
   parameter int COEF_W = 16,
   localparam int IDX_W = $clog2(NTAPS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DLY_W-1:0]              wr_dly,
   input  logic [COEF_W-1:0]             wr_coef,
   input  logic                          swap,
   output logic [NTAPS-1:0][DLY_W-1:0]   act_dly_o,
   output logic [NTAPS-1:0][COEF_W-1:0]  act_coef_o
);

   logic [NTAPS-1:0][DLY_W-1:0]  shd_dly_q,  act_dly_q;
   logic [NTAPS-1:0][COEF_W-1:0] shd_coef_q, act_coef_q;

   // Shadow side: host edits, one tap per cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd_dly_q  <= '0;
         shd_coef_q <= '0;
      end else if (wr_en) begin
         shd_dly_q[wr_idx]  <= wr_dly;
         shd_coef_q[wr_idx] <= wr_coef;
      end
   end

   // Active side: whole-bank copy on swap (a same-cycle write misses it)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_dly_q  <= '0;
         act_coef_q <= '0;
      end else if (swap) begin
         act_dly_q  <= shd_dly_q;
         act_coef_q <= shd_coef_q;
      end
   end

   assign act_dly_o  = act_dly_q;
   assign act_coef_o = act_coef_q;

   // R5
   active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !swap |=> ($stable(act_coef_q) && $stable(act_dly_q)));

   // R6
   swap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> (act_coef_q == $past(shd_coef_q)) && (act_dly_q == $past(shd_dly_q)));

   // R8
   shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (swap && !wr_en) |=> $stable(shd_coef_q));

endmodule

// File: rtl/sfir_mac.sv
module sfir_mac #(
   parameter int DATA_W = 14,
   parameter int COEF_W = 16,
   parameter int ACC_W  = 36,
   parameter int NTAPS  = 8,
   parameter int DEPTH  = 32,
   localparam int DLY_W  = $clog2(DEPTH),
   localparam int PROD_W = DATA_W + COEF_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          valid_i,
   input  logic [DEPTH-1:0][DATA_W-1:0]  hist_i,
   input  logic [NTAPS-1:0][DLY_W-1:0]   dly_i,
   input  logic [NTAPS-1:0][COEF_W-1:0]  coef_i,
   output logic                          valid_o,
   output logic [ACC_W-1:0]              acc_o
);

   logic signed [PROD_W-1:0] prod [NTAPS];
   logic signed [ACC_W-1:0]  sum;

   for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      logic [DATA_W-1:0] pick;
      if (DEPTH == (2 ** DLY_W)) begin : g_full
         assign pick = hist_i[dly_i[k]];
      end else begin : g_guard
         assign pick = (dly_i[k] < DLY_W'(DEPTH)) ? hist_i[dly_i[k]] : '0;
      end
      logic signed [PROD_W-1:0] a_ext, b_ext;
      assign a_ext   = {{(PROD_W-DATA_W){pick[DATA_W-1]}}, pick};
      assign b_ext   = {{(PROD_W-COEF_W){coef_i[k][COEF_W-1]}}, coef_i[k]};
      assign prod[k] = a_ext * b_ext;
   end

   always_comb begin
      sum = '0;
      for (int k = 0; k < NTAPS; k++)
         sum = sum + {{(ACC_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         acc_o   <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) acc_o <= sum;
      end
   end

endmodule

// File: rtl/sparse_tap_fir.sv
module sparse_tap_fir
   import sfir_pkg::*;
#(
   parameter int DATA_W = SFIR_DATA_W,
   parameter int COEF_W = SFIR_COEF_W,
   parameter int ACC_W  = SFIR_ACC_W,
   parameter int NTAPS  = SFIR_NTAPS,
   parameter int DEPTH  = SFIR_DEPTH,
   localparam int IDX_W = $clog2(NTAPS),
   localparam int DLY_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_sample,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_tap,
   input  logic [DLY_W-1:0]  cfg_delay,
   input  logic [COEF_W-1:0] cfg_coef,
   input  logic              cfg_swap,
   output logic              out_valid,
   output logic [ACC_W-1:0]  out_acc
);

   if (ACC_W < sfir_acc_need(DATA_W, COEF_W, NTAPS)) begin : g_bad_acc
      $error("sparse_tap_fir: ACC_W too narrow for DATA_W, COEF_W and NTAPS");
   end
   if (NTAPS < 2 || DEPTH < 2) begin : g_bad_shape
      $error("sparse_tap_fir: NTAPS and DEPTH must be at least 2");
   end
   if (NTAPS > DEPTH) begin : g_bad_ratio
      $error("sparse_tap_fir: NTAPS must not exceed DEPTH");
   end

   logic [DEPTH-1:0][DATA_W-1:0]  hist;
   logic [NTAPS-1:0][DLY_W-1:0]   act_dly;
   logic [NTAPS-1:0][COEF_W-1:0]  act_coef;
   logic                          s1_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) s1_valid <= 1'b0;
      else        s1_valid <= in_valid;
   end

   sfir_history #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hist (
      .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_sample), .hist_o(hist));

   sfir_bank #(.NTAPS(NTAPS), .DLY_W(DLY_W), .COEF_W(COEF_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_tap), .wr_dly(cfg_delay),
      .wr_coef(cfg_coef), .swap(cfg_swap), .act_dly_o(act_dly), .act_coef_o(act_coef));

   sfir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .NTAPS(NTAPS), .DEPTH(DEPTH)) u_mac (
      .clk(clk), .rst_n(rst_n), .valid_i(s1_valid), .hist_i(hist), .dly_i(act_dly),
      .coef_i(act_coef), .valid_o(out_valid), .acc_o(out_acc));

   // R2
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);

   // R2
   valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   // R11
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_acc));

endmodule

// File: tb/sparse_tap_fir_test.sv
module sparse_tap_fir_test;

   localparam int DATA_W = 14;
   localparam int COEF_W = 16;
   localparam int ACC_W  = 36;
   localparam int NTAPS  = 8;
   localparam int DEPTH  = 32;
   localparam int IDX_W  = 3;
   localparam int DLY_W  = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_sample = '0;
   logic              cfg_we = 1'b0;
   logic [IDX_W-1:0]  cfg_tap = '0;
   logic [DLY_W-1:0]  cfg_delay = '0;
   logic [COEF_W-1:0] cfg_coef = '0;
   logic              cfg_swap = 1'b0;
   logic              out_valid;
   logic [ACC_W-1:0]  out_acc;

   always #5 clk = ~clk;

   sparse_tap_fir uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .cfg_we(cfg_we), .cfg_tap(cfg_tap), .cfg_delay(cfg_delay), .cfg_coef(cfg_coef),
      .cfg_swap(cfg_swap), .out_valid(out_valid), .out_acc(out_acc));

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Bench reference state
   longint m_hist [DEPTH];
   longint m_act_c [NTAPS];
   int     m_act_d [NTAPS];
   longint m_shd_c [NTAPS];
   int     m_shd_d [NTAPS];
   longint ev0 = 0, ev1 = 0, ed0 = 0, ed1 = 0;
   longint last_out = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint sx14(input logic [DATA_W-1:0] v);
      return longint'($signed(v));
   endfunction

   function automatic longint sx16(input logic [COEF_W-1:0] v);
      return longint'($signed(v));
   endfunction

   // One cycle: check outputs, update reference, drive inputs, wait a cycle
   task automatic step(input bit v, input logic [DATA_W-1:0] d, input bit sw,
                       input bit we, input int tap, input int dly,
                       input logic [COEF_W-1:0] coef, input string tag);
      chk(tag, longint'(out_valid), ev1);
      if (ev1 != 0) chk(tag, longint'($signed(out_acc)), ed1);
      else          chk("R11", longint'($signed(out_acc)), last_out);
      if (out_valid) last_out = longint'($signed(out_acc));
      ev1 = ev0;
      ed1 = ed0;
      if (sw) begin
         for (int k = 0; k < NTAPS; k++) begin
            m_act_c[k] = m_shd_c[k];
            m_act_d[k] = m_shd_d[k];
         end
      end
      if (we) begin
         m_shd_c[tap] = sx16(coef);
         m_shd_d[tap] = dly;
      end
      if (v) begin
         for (int i = DEPTH - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
         m_hist[0] = sx14(d);
         ed0 = 0;
         for (int k = 0; k < NTAPS; k++) ed0 += m_act_c[k] * m_hist[m_act_d[k]];
      end
      ev0 = v;
      in_valid  = v;
      in_sample = d;
      cfg_swap  = sw;
      cfg_we    = we;
      cfg_tap   = IDX_W'(tap);
      cfg_delay = DLY_W'(dly);
      cfg_coef  = coef;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, '0, tag);
   endtask

   task automatic samples(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1, DATA_W'($urandom), 0, 0, 0, 0, '0, tag);
   endtask

   task automatic wr(input int tap, input int dly, input logic [COEF_W-1:0] c, input string tag);
      step(0, '0, 0, 1, tap, dly, c, tag);
   endtask

   task automatic swap_now(input string tag);
      step(0, '0, 1, 0, 0, 0, '0, tag);
   endtask

   task automatic t_reset;
      chk("R1", longint'(out_valid), 0);
      chk("R1", longint'($signed(out_acc)), 0);
      samples(6, "R1");
      idle(2, "R1");
   endtask

   task automatic t_latency;
      wr(0, 0, 16'd1, "R2");
      swap_now("R2");
      step(1, 14'd100, 0, 0, 0, 0, '0, "R2");
      idle(3, "R2");
      step(1, 14'd7, 0, 0, 0, 0, '0, "R2");
      step(1, 14'h3FFF, 0, 0, 0, 0, '0, "R2");
      idle(3, "R2");
   endtask

   task automatic t_single_tap;
      wr(0, 0, 16'd0, "R3");
      wr(2, 5, 16'd3, "R3");
      wr(6, 31, 16'hFFF9, "R3");
      swap_now("R3");
      samples(40, "R3");
      idle(2, "R3");
   endtask

   task automatic t_idle_gaps;
      wr(1, 1, 16'd11, "R4");
      wr(4, 3, 16'hFF00, "R4");
      swap_now("R4");
      for (int i = 0; i < 12; i++) begin
         step(1, DATA_W'($urandom), 0, 0, 0, 0, '0, "R4");
         idle(1 + (i % 3), "R4");
      end
      idle(2, "R11");
   endtask

   task automatic t_shadow_hold;
      samples(3, "R5");
      for (int k = 0; k < NTAPS; k++)
         step(1, DATA_W'($urandom), 0, 1, k, k * 3, COEF_W'(1000 + k), "R5");
      samples(4, "R5");
      idle(2, "R5");
   endtask

   task automatic t_swap_edge;
      samples(5, "R6");
      step(1, DATA_W'($urandom), 1, 0, 0, 0, '0, "R6");
      samples(5, "R6");
      idle(2, "R6");
   endtask

   task automatic t_collide;
      step(1, DATA_W'($urandom), 1, 1, 3, 2, 16'h7FFF, "R7");
      samples(4, "R7");
      swap_now("R7");
      samples(4, "R7");
      idle(2, "R7");
   endtask

   task automatic t_reswap;
      swap_now("R8");
      samples(4, "R8");
      wr(5, 9, 16'h8001, "R8");
      swap_now("R8");
      samples(12, "R8");
      idle(2, "R8");
   endtask

   task automatic t_shared_delay;
      for (int k = 0; k < NTAPS; k++) wr(k, 0, '0, "R9");
      wr(0, 4, 16'd5, "R9");
      wr(7, 4, 16'd9, "R9");
      swap_now("R9");
      samples(10, "R9");
      idle(2, "R9");
   endtask

   task automatic t_extreme;
      for (int k = 0; k < NTAPS; k++) wr(k, k, 16'h8000, "R10");
      swap_now("R10");
      for (int i = 0; i < NTAPS; i++) step(1, 14'h2000, 0, 0, 0, 0, '0, "R10");
      idle(3, "R10");
      chk("R10", last_out, 64'sd2147483648);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) m_hist[i] = 0;
      for (int k = 0; k < NTAPS; k++) begin
         m_act_c[k] = 0; m_act_d[k] = 0; m_shd_c[k] = 0; m_shd_d[k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latency();
      t_single_tap();
      t_idle_gaps();
      t_shadow_hold();
      t_swap_edge();
      t_collide();
      t_reswap();
      t_shared_delay();
      t_extreme();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule